// File: doc/BRIEF.md
# Timed-Unlock Nonvolatile Byte Store Controller

This block connects a CPU register bus to a small on-chip nonvolatile byte array. Software reaches it through three byte-wide registers chosen by a two-bit select: an address register, a data register and a control register. Reads are served directly from the array into the data register. Writes are guarded by a two-step unlock. Software first arms a master write enable. Hardware clears that enable again after a short window. A write strobe set inside the window starts a programming cycle, which stays busy for a fixed number of clocks.

While a byte is being programmed the controller reports busy and refuses further reads and writes. A separate input from the flash self-programming logic locks the array out completely. When the controller is idle, it can raise a level-sensitive ready interrupt. The array model in this project starts every location at an erased value when reset.

Top module: `eep_unlock_ctrl`

## Requirements
- R1: After reset the data register and address register read 0x00, the control register reads 0x00 and the ready interrupt is low.
- R2: Control register bits 7:4 always read as zero, whatever value is written to them.
- R3: Writing the control register with bit 2 (master write enable) at one opens an unlock window. Bit 2 reads one for exactly UNLOCK_CYC clocks and then clears by itself. A control write with bit 2 at zero closes the window at once.
- R4: A control write with bit 1 (write enable) at one starts a programming cycle when the window is open, no write is busy and the flash lockout is low. The start consumes the window.
- R5: A write-enable request that arrives after the window has expired stores nothing, and bit 1 stays zero.
- R6: A write-enable request with no window ever opened has no effect on the array or on bit 1.
- R7: Once started, bit 1 reads one for exactly PROG_CYC clocks, including when software writes it to zero. It then clears, and the byte is present in the array.
- R8: The ready interrupt output equals the ready-interrupt enable (control bit 3) AND not busy AND the global interrupt flag input.
- R9: While flash_lock is high, a write-enable request starts no write and stores nothing.
- R10: A control write with bit 0 (read enable) at one while not busy loads the data register from the array location selected by the address register at that clock edge. Bit 0 always reads zero. A read request while busy leaves the data register unchanged.
- R11: The address and data are captured when a write starts. Changes to either register during the busy period do not alter the byte stored or its location.
- R12: Register select 0 is the address register, zero-extended to 8 bits; 1 is the data register; 2 is the control register; 3 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select (0 address, 1 data, 2 control) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the selected register |
| gie | input | 1 | Global interrupt enable flag |
| flash_lock | input | 1 | Flash self-programming in progress; blocks array writes |
| rdy_irq | output | 1 | Level ready interrupt request |

## Verification
The bench builds the controller with AW=4, UNLOCK_CYC=4 and PROG_CYC=6. With the 16-byte array, the erased value of every location used can be predicted, and a corrupted write address shows up quickly. The short programming delay lets each scenario run through a full busy period. With it, the bench can place a write-enable request on each of the four open cycles of the window and on the first expired cycle. It can also change the address and data, and attempt reads, in the middle of a busy write.

// File: rtl/eep_unlock_pkg.sv
package eep_unlock_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int CTL_RIE = 3;
   localparam int CTL_MWE = 2;
   localparam int CTL_WE  = 1;
   localparam int CTL_RE  = 0;
endpackage

// File: rtl/eep_unlock_timer.sv
module eep_unlock_timer #(
   parameter int UNLOCK_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic disarm,
   output logic open_o
);
   localparam int CW = $clog2(UNLOCK_CYC + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         left_q <= '0;
      else if (disarm)
         left_q <= '0;
      else if (arm)
         left_q <= CW'(UNLOCK_CYC);
      else if (left_q != '0)
         left_q <= left_q - 1'b1;
   end

   assign open_o = (left_q != '0);
endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq #(
   parameter int AW       = 6,
   parameter int PROG_CYC = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] addr_in,
   input  logic [7:0]    data_in,
   output logic          busy,
   output logic          commit,
   output logic [AW-1:0] c_addr,
   output logic [7:0]    c_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_addr <= '0;
         c_data <= '0;
      end else if (start) begin
         c_addr <= addr_in;
         c_data <= data_in;
      end
   end

   generate
      if (PROG_CYC == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= start;
         end
         assign busy   = busy_q;
         assign commit = busy_q;
      end else begin : g_count
         localparam int PW = $clog2(PROG_CYC + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               left_q <= '0;
            else if (start)
               left_q <= PW'(PROG_CYC);
            else if (left_q != '0)
               left_q <= left_q - 1'b1;
         end
         assign busy   = (left_q != '0);
         assign commit = (left_q == PW'(1));
      end
   endgenerate
endmodule

// File: rtl/eep_byte_array.sv
module eep_byte_array #(
   parameter int         AW        = 6,
   parameter logic [7:0] ERASE_VAL = 8'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= ERASE_VAL;
      end else if (wr_en) begin
         cells[wr_addr] <= wr_data;
      end
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eep_unlock_ctrl.sv
module eep_unlock_ctrl
   import eep_unlock_pkg::*;
#(
   parameter int         AW         = 6,
   parameter int         UNLOCK_CYC = 4,
   parameter int         PROG_CYC   = 16,
   parameter logic [7:0] ERASE_VAL  = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_sel,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       gie,
   input  logic       flash_lock,
   output logic       rdy_irq
);
   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("AW must lie in 1..8");
      end
      if (UNLOCK_CYC < 1) begin : g_bad_unlock
         $error("UNLOCK_CYC must be at least 1");
      end
      if (PROG_CYC < 1) begin : g_bad_prog
         $error("PROG_CYC must be at least 1");
      end
   endgenerate

   logic          addr_wr, data_wr, ctrl_wr;
   logic          mwe_open, busy, commit, start, rd_req;
   logic [AW-1:0] addr_q, c_addr;
   logic [7:0]    data_q, c_data, arr_rd;
   logic          rie_q;
   logic [7:0]    addr_ext, ctrl_view;

   assign addr_wr = reg_wr && (reg_sel == SEL_ADDR);
   assign data_wr = reg_wr && (reg_sel == SEL_DATA);
   assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);

   assign start  = ctrl_wr && reg_wdata[CTL_WE] && mwe_open && !busy && !flash_lock;
   assign rd_req = ctrl_wr && reg_wdata[CTL_RE] && !busy;

   eep_unlock_timer #(.UNLOCK_CYC(UNLOCK_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (ctrl_wr && reg_wdata[CTL_MWE]),
      .disarm (start || (ctrl_wr && !reg_wdata[CTL_MWE])),
      .open_o (mwe_open)
   );

   eep_prog_seq #(.AW(AW), .PROG_CYC(PROG_CYC)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .addr_in (addr_q),
      .data_in (data_q),
      .busy    (busy),
      .commit  (commit),
      .c_addr  (c_addr),
      .c_data  (c_data)
   );

   eep_byte_array #(.AW(AW), .ERASE_VAL(ERASE_VAL)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (commit),
      .wr_addr (c_addr),
      .wr_data (c_data),
      .rd_addr (addr_q),
      .rd_data (arr_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         rie_q  <= 1'b0;
      end else begin
         if (addr_wr) addr_q <= reg_wdata[AW-1:0];
         if (data_wr)
            data_q <= reg_wdata;
         else if (rd_req)
            data_q <= arr_rd;
         if (ctrl_wr) rie_q <= reg_wdata[CTL_RIE];
      end
   end

   always_comb begin
      addr_ext           = '0;
      addr_ext[AW-1:0]   = addr_q;
      ctrl_view          = '0;
      ctrl_view[CTL_RIE] = rie_q;
      ctrl_view[CTL_MWE] = mwe_open;
      ctrl_view[CTL_WE]  = busy;
      unique case (reg_sel)
         SEL_ADDR: reg_rdata = addr_ext;
         SEL_DATA: reg_rdata = data_q;
         SEL_CTRL: reg_rdata = ctrl_view;
         default:  reg_rdata = 8'h00;
      endcase
   end

   assign rdy_irq = rie_q && !busy && gie;
endmodule

// File: rtl/eep_unlock_chk.sv
module eep_unlock_chk #(
   parameter int UNLOCK_CYC = 4,
   parameter int PROG_CYC   = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] reg_sel,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic       flash_lock,
   input logic       rdy_irq,
   input logic       mwe_open,
   input logic       busy,
   input logic [7:0] data_q
);
   logic [15:0] win_run, busy_run;
   logic        arm_seen;

   assign arm_seen = reg_wr && (reg_sel == 2'd2) && reg_wdata[2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_run  <= '0;
         busy_run <= '0;
      end else begin
         win_run  <= arm_seen ? 16'd0 : (mwe_open ? win_run + 16'd1 : 16'd0);
         busy_run <= busy ? busy_run + 16'd1 : 16'd0;
      end
   end

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd2) |-> (reg_rdata[7:4] == 4'h0));

   p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mwe_open |-> (win_run < 16'(UNLOCK_CYC)));

   p_start_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(mwe_open));

   p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run < 16'(PROG_CYC)));

   p_busy_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == 16'(PROG_CYC)));

   p_irq_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rdy_irq);

   p_flash_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(flash_lock));

   p_read_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && (reg_sel == 2'd2) && reg_wdata[0]) |=> $stable(data_q));
endmodule

bind eep_unlock_ctrl eep_unlock_chk #(.UNLOCK_CYC(UNLOCK_CYC), .PROG_CYC(PROG_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_sel    (reg_sel),
   .reg_wr     (reg_wr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .flash_lock (flash_lock),
   .rdy_irq    (rdy_irq),
   .mwe_open   (mwe_open),
   .busy       (busy),
   .data_q     (data_q)
);

// File: tb/eep_unlock_ctrl_bench.sv
module eep_unlock_ctrl_bench;
   localparam int AW = 4;
   localparam int UNL = 4;
   localparam int PRG = 6;
   localparam int DEPTH = 1 << AW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       gie = 1'b1;
   logic       flash_lock = 1'b0;
   logic       rdy_irq;

   int vectors = 0;
   int fails = 0;
   int cycles = 0;

   int m_addr, m_data, m_rie, m_mwe, m_busy, m_la, m_ld;
   int mem [DEPTH];

   always #2.5 clk = ~clk;

   eep_unlock_ctrl #(.AW(AW), .UNLOCK_CYC(UNL), .PROG_CYC(PRG), .ERASE_VAL(8'hFF)) u_eep_unlock_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie),
      .flash_lock(flash_lock), .rdy_irq(rdy_irq)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++;
         $display("FAIL watchdog: run did not finish (act cycles=%0d, exp < 20000)", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic model_reset();
      m_addr = 0; m_data = 0; m_rie = 0; m_mwe = 0; m_busy = 0; m_la = 0; m_ld = 0;
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
   endtask

   task automatic model_step();
      bit cw, st, rd;
      cw = reg_wr && reg_sel == 2'd2;
      st = cw && reg_wdata[1] && m_mwe > 0 && m_busy == 0 && !flash_lock;
      rd = cw && reg_wdata[0] && m_busy == 0;
      if (m_busy == 1) mem[m_la] = m_ld;
      if (st) begin m_la = m_addr; m_ld = m_data; end
      if (rd) m_data = mem[m_addr];
      if (st) m_busy = PRG;
      else if (m_busy > 0) m_busy--;
      if (st) m_mwe = 0;
      else if (cw && reg_wdata[2]) m_mwe = UNL;
      else if (cw) m_mwe = 0;
      else if (m_mwe > 0) m_mwe--;
      if (reg_wr && reg_sel == 2'd0) m_addr = reg_wdata % DEPTH;
      if (reg_wr && reg_sel == 2'd1) m_data = reg_wdata;
      if (cw) m_rie = reg_wdata[3];
   endtask

   function automatic int model_rdata();
      case (reg_sel)
         2'd0: return m_addr;
         2'd1: return m_data;
         2'd2: return (m_rie << 3) | ((m_mwe > 0) << 2) | ((m_busy > 0) << 1);
         default: return 0;
      endcase
   endfunction

   task automatic compare(input string tag);
      int er, ei;
      er = model_rdata();
      ei = (m_rie != 0 && m_busy == 0 && gie) ? 1 : 0;
      vectors++;
      if (reg_rdata !== 8'(er) || rdy_irq !== 1'(ei)) begin
         fails++;
         $display("FAIL %s: sel=%0d act rdata=%02h irq=%0b exp rdata=%02h irq=%0b",
                  tag, reg_sel, reg_rdata, rdy_irq, er, ei);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic step(input logic [1:0] s, input logic w, input logic [7:0] d, input string tag);
      reg_sel = s; reg_wr = w; reg_wdata = d;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input int n, input logic [1:0] s, input string tag);
      for (int i = 0; i < n; i++) step(s, 1'b0, 8'h00, tag);
   endtask

   task automatic read_loc(input int a, input string tag);
      step(2'd0, 1'b1, 8'(a), tag);
      step(2'd2, 1'b1, 8'h01, tag);
      step(2'd1, 1'b0, 8'h00, tag);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      idle(1, 2'd2, "R1");
      idle(1, 2'd1, "R1");
      idle(1, 2'd0, "R1");
      // R2: reserved bits
      step(2'd2, 1'b1, 8'hF0, "R2");
      idle(1, 2'd2, "R2");
      // R12: address zero-extension and unused select
      step(2'd0, 1'b1, 8'h3A, "R12");
      idle(1, 2'd0, "R12");
      idle(1, 2'd3, "R12");
      // R3: window self-clear and software close
      step(2'd2, 1'b1, 8'h04, "R3");
      idle(6, 2'd2, "R3");
      step(2'd2, 1'b1, 8'h04, "R3");
      step(2'd2, 1'b1, 8'h00, "R3");
      idle(1, 2'd2, "R3");
      // R4 / R7: write at every open cycle of the window
      for (int k = 0; k < UNL; k++) begin
         step(2'd0, 1'b1, 8'(k + 1), "R4");
         step(2'd1, 1'b1, 8'(8'h50 + k), "R4");
         step(2'd2, 1'b1, 8'h04, "R4");
         idle(k, 2'd2, "R4");
         step(2'd2, 1'b1, 8'h02, "R4");
         idle(PRG + 1, 2'd2, "R7");
         read_loc(k + 1, "R4");
      end
      // R5: window expired
      step(2'd0, 1'b1, 8'h07, "R5");
      step(2'd1, 1'b1, 8'hA5, "R5");
      step(2'd2, 1'b1, 8'h04, "R5");
      idle(UNL, 2'd2, "R5");
      step(2'd2, 1'b1, 8'h02, "R5");
      idle(2, 2'd2, "R5");
      read_loc(7, "R5");
      // R6: no window at all
      step(2'd1, 1'b1, 8'h3C, "R6");
      step(2'd2, 1'b1, 8'h02, "R6");
      idle(2, 2'd2, "R6");
      read_loc(7, "R6");
      // R7 / R11 / R10: clear attempt, register changes and read during busy
      step(2'd0, 1'b1, 8'h09, "R11");
      step(2'd1, 1'b1, 8'hC3, "R11");
      step(2'd2, 1'b1, 8'h04, "R11");
      step(2'd2, 1'b1, 8'h02, "R11");
      step(2'd2, 1'b1, 8'h00, "R7");
      step(2'd0, 1'b1, 8'h0A, "R11");
      step(2'd1, 1'b1, 8'h11, "R11");
      step(2'd2, 1'b1, 8'h01, "R10");
      idle(1, 2'd1, "R10");
      idle(PRG, 2'd2, "R7");
      read_loc(9, "R11");
      read_loc(10, "R11");
      // R8: interrupt level across gie and busy
      step(2'd2, 1'b1, 8'h08, "R8");
      gie = 1'b0; idle(1, 2'd2, "R8");
      gie = 1'b1; idle(1, 2'd2, "R8");
      step(2'd2, 1'b1, 8'h0C, "R8");
      step(2'd2, 1'b1, 8'h0A, "R8");
      idle(PRG + 1, 2'd2, "R8");
      step(2'd2, 1'b1, 8'h00, "R8");
      // R9: flash lockout
      step(2'd0, 1'b1, 8'h0C, "R9");
      step(2'd1, 1'b1, 8'h66, "R9");
      step(2'd2, 1'b1, 8'h04, "R9");
      flash_lock = 1'b1;
      step(2'd2, 1'b1, 8'h02, "R9");
      idle(PRG + 1, 2'd2, "R9");
      flash_lock = 1'b0;
      read_loc(12, "R9");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule